// File: doc/BRIEF.md
# Interrupt Delay Timer Unit

This block moderates completion interrupts for one receive ring and one transmit ring. Each direction owns two countdown timers. The packet delay timer re-arms on every completion. The absolute delay timer caps the total wait from the first completion that finds it idle. Timer values are written through a small select/value port and count in units of `UNIT_CYCLES` clock cycles. At 200 MHz the default of 205 cycles gives about 1024 ns per unit.

When a timer of a direction runs out, the block does not raise an interrupt cause straight away. It first pulses a flush request to that direction's descriptor writeback engine. The request means "write back whatever is used, with no alignment". One cycle later it pulses the cause for that direction: receive-timer for the receive ring, descriptor-written-back for the transmit ring. When the writeback engine reports that it has already posted its cause on its own, both timers of that direction are cancelled.

Top module: `irq_delay_timers`

## Requirements
- R1: After reset all four delay values are zero and every flush and cause output is low.
- R2: A completion with delay value N sampled at clock edge k makes the direction's flush output high for the one cycle after edge k+N*UNIT_CYCLES.
- R3: Each expiry produces a single-cycle flush pulse and, in the following cycle, a single-cycle cause pulse of the same direction.
- R4: The packet delay timer restarts from its full value on every completion. A completion sampled at the edge where it would expire suppresses that expiry.
- R5: The absolute delay timer is armed only by a completion that finds it idle, or one that arrives at its expiry edge. Completions while it runs do not move its expiry.
- R6: A delay value of zero disables that timer: completions never produce an expiry from it.
- R7: Receive timers drive only `rx_flush_o`/`rx_cause_o` and transmit timers drive only `tx_flush_o`/`tx_cause_o`.
- R8: A writeback-posted strobe stops both timers of its direction. An expiry due at that same edge is dropped, and a completion at that edge arms afresh.
- R9: When both timers of one direction expire at the same edge, exactly one flush pulse and one cause pulse result.
- R10: Timer values are written with `cfg_sel_i` encoded as 0 = rx packet, 1 = rx absolute, 2 = tx packet, 3 = tx absolute. A value is captured when a timer is armed, so a write during a run does not change that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Delay value write strobe |
| cfg_sel_i | input | 2 | Which timer value to write (see R10) |
| cfg_val_i | input | TVAL_W | Delay value in time units |
| rx_done_i | input | 1 | Receive completion strobe |
| tx_done_i | input | 1 | Transmit completion strobe |
| rx_wb_posted_i | input | 1 | Receive writeback already posted its cause |
| tx_wb_posted_i | input | 1 | Transmit writeback already posted its cause |
| rx_flush_o | output | 1 | Unaligned writeback request, receive ring |
| rx_cause_o | output | 1 | Receive-timer cause pulse |
| tx_flush_o | output | 1 | Unaligned writeback request, transmit ring |
| tx_cause_o | output | 1 | Descriptor-written-back cause pulse |

## Verification
The collision that matters is the packet timer and the absolute timer of the transmit direction running out at the same edge. Both are given the same value and armed by a single completion. The scoreboard then demands a single flush pulse followed by a single cause pulse; a doubled pulse or a missing cause is a miscompare. A second overlap is also covered: a writeback-posted strobe that falls inside a live countdown. A quiet window afterwards shows that no pulse leaks out.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {
    SEL_RX_PKT = 2'd0,
    SEL_RX_ABS = 2'd1,
    SEL_TX_PKT = 2'd2,
    SEL_TX_ABS = 2'd3
  } tsel_e;

  typedef enum logic {
    MODE_PKT = 1'b0,
    MODE_ABS = 1'b1
  } tmode_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned NUM_TMR = 2 * NUM_DIR;
endpackage

// File: rtl/irqd_cfg_regs.sv
module irqd_cfg_regs
  import irqd_pkg::*;
#(
  parameter int unsigned TVAL_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [1:0]                      sel_i,
  input  logic [TVAL_W-1:0]               val_i,
  output logic [NUM_TMR-1:0][TVAL_W-1:0]  val_o
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_reg
    logic [TVAL_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && sel_i == 2'(t)) q <= val_i;
    end
    assign val_o[t] = q;
  end
endmodule

// File: rtl/irqd_timer.sv
module irqd_timer
  import irqd_pkg::*;
#(
  parameter int unsigned TVAL_W      = 16,
  parameter int unsigned UNIT_CYCLES = 205,
  parameter tmode_e      MODE        = MODE_PKT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TVAL_W-1:0] val_i,
  input  logic              arm_i,
  input  logic              cancel_i,
  output logic              expire_o
);
  localparam int unsigned SUB_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_CYCLES - 1);

  logic              run_q, exp_q;
  logic [TVAL_W-1:0] rem_q;
  logic [SUB_W-1:0]  sub_q;
  logic              wrap, last, load;

  assign wrap = (sub_q == SUB_LAST);
  assign last = run_q && wrap && (rem_q == TVAL_W'(1));

  if (MODE == MODE_PKT) begin : g_pkt
    assign load = arm_i && (val_i != '0);
  end else begin : g_abs
    // idle, or freed by the expiry at this very edge
    assign load = arm_i && (val_i != '0) && (!run_q || (last && !cancel_i) || cancel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
      rem_q <= '0;
      sub_q <= '0;
    end else begin
      exp_q <= 1'b0;
      if (cancel_i) begin
        run_q <= 1'b0;
      end else if (last) begin
        run_q <= 1'b0;
        exp_q <= 1'b1;
      end else if (run_q) begin
        if (wrap) begin
          sub_q <= '0;
          rem_q <= rem_q - TVAL_W'(1);
        end else begin
          sub_q <= sub_q + SUB_W'(1);
        end
      end
      if (load) begin
        run_q <= 1'b1;
        rem_q <= val_i;
        sub_q <= '0;
        if (MODE == MODE_PKT) exp_q <= 1'b0;
      end
    end
  end

  assign expire_o = exp_q;
endmodule

// File: rtl/irqd_dir.sv
module irqd_dir
  import irqd_pkg::*;
#(
  parameter int unsigned TVAL_W      = 16,
  parameter int unsigned UNIT_CYCLES = 205
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TVAL_W-1:0] pkt_val_i,
  input  logic [TVAL_W-1:0] abs_val_i,
  input  logic              done_i,
  input  logic              cancel_i,
  output logic              flush_o,
  output logic              cause_o
);
  logic pkt_exp, abs_exp, cause_q;

  irqd_timer #(.TVAL_W(TVAL_W), .UNIT_CYCLES(UNIT_CYCLES), .MODE(MODE_PKT)) u_pkt (
    .clk_i, .rst_ni, .val_i(pkt_val_i), .arm_i(done_i), .cancel_i, .expire_o(pkt_exp)
  );

  irqd_timer #(.TVAL_W(TVAL_W), .UNIT_CYCLES(UNIT_CYCLES), .MODE(MODE_ABS)) u_abs (
    .clk_i, .rst_ni, .val_i(abs_val_i), .arm_i(done_i), .cancel_i, .expire_o(abs_exp)
  );

  assign flush_o = pkt_exp | abs_exp;

  // cause trails the flush request by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= 1'b0;
    else         cause_q <= flush_o;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_delay_timers.sv
module irq_delay_timers
  import irqd_pkg::*;
#(
  parameter int unsigned TVAL_W      = 16,
  parameter int unsigned UNIT_CYCLES = 205
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [TVAL_W-1:0] cfg_val_i,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  input  logic              rx_wb_posted_i,
  input  logic              tx_wb_posted_i,
  output logic              rx_flush_o,
  output logic              rx_cause_o,
  output logic              tx_flush_o,
  output logic              tx_cause_o
);
  logic [NUM_TMR-1:0][TVAL_W-1:0] vals;
  logic [NUM_DIR-1:0] done, cancel, flush, cause;

  irqd_cfg_regs #(.TVAL_W(TVAL_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .val_i(cfg_val_i), .val_o(vals)
  );

  assign done   = {tx_done_i, rx_done_i};
  assign cancel = {tx_wb_posted_i, rx_wb_posted_i};

  // direction d uses value slots 2d (packet) and 2d+1 (absolute)
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    irqd_dir #(.TVAL_W(TVAL_W), .UNIT_CYCLES(UNIT_CYCLES)) u_dir (
      .clk_i, .rst_ni,
      .pkt_val_i(vals[2*d]),
      .abs_val_i(vals[2*d+1]),
      .done_i(done[d]),
      .cancel_i(cancel[d]),
      .flush_o(flush[d]),
      .cause_o(cause[d])
    );
  end

  assign rx_flush_o = flush[0];
  assign rx_cause_o = cause[0];
  assign tx_flush_o = flush[1];
  assign tx_cause_o = cause[1];
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int unsigned TVAL_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [1:0]        cfg_sel_i,
  input logic [TVAL_W-1:0] cfg_val_i,
  input logic              rx_done_i,
  input logic              tx_done_i,
  input logic              rx_wb_posted_i,
  input logic              tx_wb_posted_i,
  input logic              rx_flush_o,
  input logic              rx_cause_o,
  input logic              tx_flush_o,
  input logic              tx_cause_o
);
  a_r3_rx_cause_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |=> rx_cause_o);
  a_r3_tx_cause_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |=> tx_cause_o);
  a_r3_rx_cause_needs_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_cause_o) |-> $past(rx_flush_o));
  a_r8_rx_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wb_posted_i |=> !rx_flush_o);
  a_r8_tx_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wb_posted_i |=> !tx_flush_o);
endmodule

bind irq_delay_timers irqd_checker #(.TVAL_W(TVAL_W)) u_chk (.*);

// File: tb/irq_delay_timers_test.sv
`timescale 1ns/1ps
module irq_delay_timers_test;
  localparam int U  = 4;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [TW-1:0] cfg_val = '0;
  logic rx_done = 1'b0, tx_done = 1'b0, rx_wb = 1'b0, tx_wb = 1'b0;
  logic rx_flush, rx_cause, tx_flush, tx_cause;

  always #2.5 clk = ~clk;

  irq_delay_timers #(.TVAL_W(TW), .UNIT_CYCLES(U)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_val_i(cfg_val),
    .rx_done_i(rx_done), .tx_done_i(tx_done), .rx_wb_posted_i(rx_wb), .tx_wb_posted_i(tx_wb),
    .rx_flush_o(rx_flush), .rx_cause_o(rx_cause), .tx_flush_o(tx_flush), .tx_cause_o(tx_cause)
  );

  typedef struct {
    int         cyc;
    logic [3:0] bits; // {tx_cause, tx_flush, rx_cause, rx_flush}
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0, checks = 0, fails = 0, pulses = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: merge everything expected for this cycle and compare
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] act, expv;
      string tag;
      act  = {tx_cause, tx_flush, rx_cause, rx_flush};
      expv = '0;
      tag  = cur_req;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          expv |= q[i].bits;
          tag = q[i].tag;
          q.delete(i);
        end
      end
      if (act != 0) pulses++;
      if (expv != 0 || act != 0) begin
        checks++;
        if (act !== expv) begin
          fails++;
          $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, expv);
        end
      end
    end
  end

  task automatic expect_fire(input int edge_k, input bit tx, input string tag);
    q.push_back('{cyc: edge_k,     bits: tx ? 4'b0100 : 4'b0001, tag: tag});
    q.push_back('{cyc: edge_k + 1, bits: tx ? 4'b1000 : 4'b0010, tag: tag});
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_val = TW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic done(input bit tx, output int arm);
    @(negedge clk);
    if (tx) tx_done = 1'b1; else rx_done = 1'b1;
    arm = cyc + 1;
    @(negedge clk);
    tx_done = 1'b0; rx_done = 1'b0;
  endtask

  task automatic wb_posted(input bit tx);
    @(negedge clk);
    if (tx) tx_wb = 1'b1; else rx_wb = 1'b1;
    @(negedge clk);
    tx_wb = 1'b0; rx_wb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input string r, input int n);
    int p0;
    p0 = pulses;
    idle(n);
    checks++;
    if (pulses != p0) begin
      fails++;
      $display("FAIL %s quiet window actual %0d pulses expected 0", r, pulses - p0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int a, b, dummy;
    idle(3);
    checks++;
    if ({tx_cause, tx_flush, rx_cause, rx_flush} !== 4'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b expected 0000", {tx_cause, tx_flush, rx_cause, rx_flush});
    end
    rst_n = 1'b1;
    idle(2);

    // R1: zero values after reset, completions do nothing
    cur_req = "R1";
    done(1'b0, dummy); done(1'b1, dummy);
    quiet("R1", 40);

    // R2 / R3 / R10: sel 0 is rx packet
    cur_req = "R2";
    cfg(2'd0, 3);
    done(1'b0, a);
    expect_fire(a + 3*U, 1'b0, "R2");
    idle(20);

    // R4 packet restart
    cur_req = "R4";
    done(1'b0, a);
    idle(3);
    done(1'b0, b);
    expect_fire(b + 3*U, 1'b0, "R4");
    idle(20);

    // R5 absolute not moved by later completions
    cur_req = "R5";
    cfg(2'd0, 0);
    cfg(2'd1, 5);
    done(1'b0, a);
    idle(5); done(1'b0, dummy);
    idle(5); done(1'b0, dummy);
    expect_fire(a + 5*U, 1'b0, "R5");
    idle(30);

    // R7 transmit packet timer only hits tx outputs
    cur_req = "R7";
    cfg(2'd2, 2);
    done(1'b1, a);
    expect_fire(a + 2*U, 1'b1, "R7");
    idle(15);

    // R9 both tx timers expire together
    cur_req = "R9";
    cfg(2'd3, 2);
    done(1'b1, a);
    expect_fire(a + 2*U, 1'b1, "R9");
    idle(15);

    // R8 cancel mid-run, both directions
    cur_req = "R8";
    done(1'b0, a);
    idle(8);
    wb_posted(1'b0);
    quiet("R8", 30);
    done(1'b1, a);
    idle(3);
    wb_posted(1'b1);
    quiet("R8", 20);

    // R10 write during a run does not change it; next arm uses the new value
    cur_req = "R10";
    cfg(2'd1, 0);
    cfg(2'd0, 3);
    done(1'b0, a);
    cfg(2'd0, 10);
    expect_fire(a + 3*U, 1'b0, "R10");
    idle(20);
    done(1'b0, b);
    expect_fire(b + 10*U, 1'b0, "R10");
    idle(50);

    // R6 explicit zero disables
    cur_req = "R6";
    cfg(2'd0, 0); cfg(2'd2, 0); cfg(2'd3, 0);
    done(1'b0, dummy); done(1'b1, dummy);
    quiet("R6", 60);

    finished = 1'b1;
    foreach (q[i]) begin
      fails++;
      $display("FAIL %s cycle %0d actual none expected %b", q[i].tag, q[i].cyc, q[i].bits);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule